// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block carries out multi-word transfers between a register file and memory. A caller starts it with a base address, a bit mask of selected registers, a direction, an address-ordering mode and a write-back flag. The block then issues one word request per selected register, one at a time. Each request carries a word address, a register index and a write flag. The block holds each request until memory answers with ready. When all words are done, it reports the new base value and a write-back strobe.

Two stack shorthands are also accepted. Push stores the list below the stack pointer. Pop restores the list from the stack pointer. For a pop, or any load, that includes the program-counter register, the loaded word is checked as a branch target. If bit 0 is set, the block drives a branch with bit 0 cleared. If bit 0 is clear, it raises a usage fault instead.

The controller has three states:
- IDLE waits for `start`. It moves to XFER when the list has bits set, or straight to FINISH when the list is empty.
- XFER issues requests. On each accepted request it stays in XFER, and it moves to FINISH after the last one.
- FINISH lasts one cycle, raises `done` and the write-back and branch results, then returns to IDLE.

Top module: `lsm_sequencer`

## Requirements
- R1: In increment-after mode (`dec_before`=0), the first request address is the base, and each following request address is 4 higher.
- R2: In decrement-before mode (`dec_before`=1), the first request address is base − 4·n, where n is the number of set bits in `reg_list`. Each following request address is 4 higher.
- R3: Exactly one request is issued per set bit of `reg_list`. Requests go in ascending register index order, and `mem_idx` gives that index.
- R4: `done` is high for one cycle, in the cycle after the last accepted request. With `wback`=1, `wb_valid` is high in that cycle and `wb_value` is base + 4·n (increment-after) or base − 4·n (decrement-before). With `wback`=0, `wb_valid` stays low, so the base keeps its value.
- R5: An empty `reg_list` issues no request. It gives `done` one cycle after `start`, with `wb_valid` low.
- R6: The `op` encoding is 0 = general transfer, 1 = push, 2 = pop, and 3 = general transfer. Push uses `sp_addr` as base and acts as a store in decrement-before mode with write-back. `wb_sp`=1 marks that the stack pointer is the target.
- R7: Pop uses `sp_addr` as base and acts as a load in increment-after mode with write-back, with `wb_sp`=1. For op 0 or 3, `wb_sp`=0.
- R8: When a load includes register index NREG−1 (the program counter) and the word read has bit 0 set, `br_valid` is high with `done`. `br_target` is then that word with bit 0 cleared.
- R9: When such a loaded word has bit 0 clear, `usage_fault` is high with `done` and `br_valid` stays low.
- R10: A request keeps its address and index stable while `mem_ready` is low. A `start`, or a change of the command inputs, while `busy` is high has no effect on the running transfer.
- R11: `mem_write` is 1 for a store (`is_load`=0 or push) and 0 for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| op | input | 2 | 0/3 general, 1 push, 2 pop |
| is_load | input | 1 | General transfer direction: 1 load, 0 store |
| dec_before | input | 1 | General transfer mode: 1 decrement-before, 0 increment-after |
| wback | input | 1 | General transfer write-back request |
| base_addr | input | ADDR_W | Base address for general transfers |
| sp_addr | input | ADDR_W | Stack pointer value for push/pop |
| reg_list | input | NREG | Selected registers |
| mem_rdata | input | ADDR_W | Read word, valid with mem_ready on a load |
| mem_ready | input | 1 | Memory accepts/completes the current request |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Request valid |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_idx | output | IDX_W | Register index of the request |
| mem_write | output | 1 | 1 store, 0 load |
| done | output | 1 | End-of-transfer pulse |
| wb_valid | output | 1 | Write the base register with wb_value |
| wb_sp | output | 1 | Base register is the stack pointer |
| wb_value | output | ADDR_W | Updated base |
| br_valid | output | 1 | Branch to br_target |
| br_target | output | ADDR_W | Branch address, bit 0 cleared |
| usage_fault | output | 1 | Loaded program counter value had bit 0 clear |

## Verification
The bench builds the block with NREG=8 and ADDR_W=32, so the program counter is index 7. At that size every one of the 256 register lists can be swept against all four general mode and direction pairs, with and without write-back, and as both push and pop. The sweep covers the empty list, single registers, the full list, and lists with the program counter in every position. The memory model stalls ready in a pattern that changes with the list, so held requests are exercised throughout. For lists that include the program counter, the loaded word's bit 0 alternates between list values, so branch and fault results both occur.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        OP_GEN  = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_GEN2 = 2'd3
    } lsm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // lowest set bit wins: scan from the top so the last hit is the lowest
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_count.sv
module lsm_count #(
    parameter int NREG  = 16,
    parameter int CNT_W = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0]  mask,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end
endmodule

// File: rtl/lsm_span.sv
module lsm_span #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dec,
    output logic [ADDR_W-1:0] first,
    output logic [ADDR_W-1:0] final_base
);
    logic [ADDR_W-1:0] bytes;

    always_comb begin
        bytes = ADDR_W'(cnt) << 2;
        if (dec) begin
            first      = base - bytes;
            final_base = base - bytes;
        end else begin
            first      = base;
            final_base = base + bytes;
        end
    end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int CNT_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              is_load,
    input  logic              dec_before,
    input  logic              wback,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] sp_addr,
    input  logic [NREG-1:0]   reg_list,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  mem_idx,
    output logic              mem_write,
    output logic              done,
    output logic              wb_valid,
    output logic              wb_sp,
    output logic [ADDR_W-1:0] wb_value,
    output logic              br_valid,
    output logic [ADDR_W-1:0] br_target,
    output logic              usage_fault
);
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);

    lsm_state_e state_q, state_d;

    logic [NREG-1:0]   rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load_q, wb_q, sp_q;
    logic [ADDR_W-1:0] wbval_q;
    logic              pc_hit_q;
    logic [ADDR_W-1:0] pc_val_q;

    // command decode
    lsm_op_e           op_e;
    logic              eff_load, eff_dec, eff_wb, eff_sp;
    logic [ADDR_W-1:0] eff_base;

    always_comb begin
        op_e     = lsm_op_e'(op);
        eff_load = is_load;
        eff_dec  = dec_before;
        eff_wb   = wback;
        eff_sp   = 1'b0;
        eff_base = base_addr;
        unique case (op_e)
            OP_PUSH: begin
                eff_load = 1'b0; eff_dec = 1'b1; eff_wb = 1'b1;
                eff_sp = 1'b1; eff_base = sp_addr;
            end
            OP_POP: begin
                eff_load = 1'b1; eff_dec = 1'b0; eff_wb = 1'b1;
                eff_sp = 1'b1; eff_base = sp_addr;
            end
            OP_GEN, OP_GEN2: ;
        endcase
    end

    logic [CNT_W-1:0]  list_cnt;
    logic [ADDR_W-1:0] first_addr, end_base;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any;
    logic [NREG-1:0]   rem_next;

    lsm_count #(.NREG(NREG), .CNT_W(CNT_W)) u_count (
        .mask(reg_list), .cnt(list_cnt)
    );

    lsm_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_span (
        .base(eff_base), .cnt(list_cnt), .dec(eff_dec),
        .first(first_addr), .final_base(end_base)
    );

    lsm_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .mask(rem_q), .idx(cur_idx), .any(cur_any)
    );

    always_comb begin
        rem_next          = rem_q;
        rem_next[cur_idx] = 1'b0;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (reg_list == '0) ? ST_FINISH : ST_XFER;
            ST_XFER:   if (mem_ready && rem_next == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            addr_q   <= '0;
            load_q   <= 1'b0;
            wb_q     <= 1'b0;
            sp_q     <= 1'b0;
            wbval_q  <= '0;
            pc_hit_q <= 1'b0;
            pc_val_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                rem_q    <= reg_list;
                addr_q   <= first_addr;
                load_q   <= eff_load;
                wb_q     <= eff_wb && (reg_list != '0);
                sp_q     <= eff_sp;
                wbval_q  <= end_base;
                pc_hit_q <= 1'b0;
            end else if (state_q == ST_XFER && mem_ready) begin
                rem_q  <= rem_next;
                addr_q <= addr_q + ADDR_W'(4);
                if (load_q && cur_idx == PC_IDX) begin
                    pc_hit_q <= 1'b1;
                    pc_val_q <= mem_rdata;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_req     = (state_q == ST_XFER) && cur_any;
        mem_addr    = addr_q;
        mem_idx     = cur_idx;
        mem_write   = !load_q;
        done        = (state_q == ST_FINISH);
        wb_valid    = done && wb_q;
        wb_sp       = sp_q;
        wb_value    = wbval_q;
        br_valid    = done && pc_hit_q && pc_val_q[0];
        usage_fault = done && pc_hit_q && !pc_val_q[0];
        br_target   = {pc_val_q[ADDR_W-1:1], 1'b0};
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_idx)));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4)));

    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_idx > $past(mem_idx)));

    p_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (!br_target[0] && !usage_fault));

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !wb_valid));
endmodule

// File: tb/test_lsm_sequencer.sv
module test_lsm_sequencer;
    localparam int AW   = 32;
    localparam int NR   = 8;
    localparam int IW   = $clog2(NR);
    localparam int PC   = NR - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic          is_load = 1'b0, dec_before = 1'b0, wback = 1'b0;
    logic [AW-1:0] base_addr = '0, sp_addr = '0;
    logic [NR-1:0] reg_list = '0;
    logic [AW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          busy, mem_req, mem_write, done, wb_valid, wb_sp;
    logic          br_valid, usage_fault;
    logic [AW-1:0] mem_addr, wb_value, br_target;
    logic [IW-1:0] mem_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lsm_sequencer #(.ADDR_W(AW), .NREG(NR)) i_lsm_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_load(is_load),
        .dec_before(dec_before), .wback(wback), .base_addr(base_addr),
        .sp_addr(sp_addr), .reg_list(reg_list), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_idx(mem_idx), .mem_write(mem_write),
        .done(done), .wb_valid(wb_valid), .wb_sp(wb_sp), .wb_value(wb_value),
        .br_valid(br_valid), .br_target(br_target), .usage_fault(usage_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // run one transfer and check every request and the end result
    task automatic run_op(input logic [1:0] o, input bit ld, input bit dc, input bit wb,
                          input logic [NR-1:0] lst, input logic [AW-1:0] b,
                          input logic [AW-1:0] sp, input bit pcbit, input bit poke);
        bit e_ld, e_dc, e_wb, e_sp;
        logic [AW-1:0] e_base, e_addr, e_final;
        int n, nxt, seen, cyc;
        logic [AW-1:0] pcword;
        bit pc_loaded;
        e_ld = ld; e_dc = dc; e_wb = wb; e_sp = 0; e_base = b;
        if (o == 2'd1) begin e_ld = 0; e_dc = 1; e_wb = 1; e_sp = 1; e_base = sp; end
        if (o == 2'd2) begin e_ld = 1; e_dc = 0; e_wb = 1; e_sp = 1; e_base = sp; end
        n = $countones(lst);
        e_addr  = e_dc ? e_base - AW'(4 * n) : e_base;
        e_final = e_dc ? e_base - AW'(4 * n) : e_base + AW'(4 * n);
        pc_loaded = e_ld && lst[PC];
        pcword = 32'h0000_4000 | AW'(pcbit);

        @(negedge clk);
        op = o; is_load = ld; dec_before = dc; wback = wb;
        reg_list = lst; base_addr = b; sp_addr = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nxt = 0; seen = 0; cyc = 0;
        while (!done && cyc < 100) begin
            if (poke && cyc == 0) begin
                // R10: new command while busy must be ignored
                start = 1'b1; base_addr = b + 32'h100; sp_addr = sp + 32'h100;
                reg_list = ~lst; op = 2'd0; is_load = ~ld; dec_before = ~dc;
            end else if (poke && cyc == 1) begin
                start = 1'b0;
            end
            if (mem_req) begin
                while (nxt < NR && !lst[nxt]) nxt++;
                chk(mem_addr == e_addr, e_dc ? "R2 address" : "R1 address", mem_addr, e_addr);
                chk(int'(mem_idx) == nxt, "R3 index order", AW'(mem_idx), AW'(nxt));
                chk(mem_write == !e_ld, "R11 direction", AW'(mem_write), AW'(!e_ld));
                mem_ready = ((cyc + int'(lst)) % 3) != 1;
                mem_rdata = (nxt == PC) ? pcword : mem_addr;
                if (mem_ready) begin
                    e_addr = e_addr + 32'd4; nxt++; seen++;
                end
            end
            @(negedge clk);
            mem_ready = 1'b0;
            cyc++;
        end
        start = 1'b0;
        if (!done) begin
            chk(0, "R4 done never seen", 0, 1);
        end else begin
            chk(seen == n, "R3 request count", AW'(seen), AW'(n));
            chk(wb_valid == (e_wb && n != 0), (n == 0) ? "R5 empty no write-back" : "R4 write-back strobe",
                AW'(wb_valid), AW'(e_wb && n != 0));
            if (e_wb && n != 0)
                chk(wb_value == e_final, "R4 write-back value", wb_value, e_final);
            chk(wb_sp == e_sp, (o == 2'd1) ? "R6 stack target" : "R7 stack target", AW'(wb_sp), AW'(e_sp));
            chk(br_valid == (pc_loaded && pcbit), "R8 branch valid", AW'(br_valid), AW'(pc_loaded && pcbit));
            chk(usage_fault == (pc_loaded && !pcbit), "R9 usage fault", AW'(usage_fault), AW'(pc_loaded && !pcbit));
            if (pc_loaded && pcbit)
                chk(br_target == 32'h0000_4000, "R8 target bit0 cleared", br_target, 32'h0000_4000);
            @(negedge clk);
            chk(!done && !busy, "R4 single done pulse", AW'({done, busy}), 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done && !wb_valid, "R5 reset state",
            AW'({busy, mem_req, done, wb_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4 directed: base 0x8000, four registers, increment-after, write-back -> 0x8010
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 8'h0F, 32'h8000, 32'h0, 1'b0, 1'b0);
        // R10 directed: poke during run
        run_op(2'd0, 1'b1, 1'b1, 1'b1, 8'h5A, 32'h9000, 32'h0, 1'b0, 1'b1);
        run_op(2'd1, 1'b0, 1'b0, 1'b0, 8'h83, 32'h0, 32'h2000_8000, 1'b0, 1'b1);
        // R5 empty
        run_op(2'd0, 1'b1, 1'b0, 1'b1, 8'h00, 32'h8000, 32'h0, 1'b0, 1'b0);
        // R8/R9 directed pops through the program counter
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 8'h80, 32'h0, 32'h2000_0F00, 1'b1, 1'b0);
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 8'h91, 32'h0, 32'h2000_0F00, 1'b0, 1'b0);

        // full sweep of general transfers (R1..R5, R8, R9, R11)
        for (int l = 0; l < 256; l++) begin
            for (int m = 0; m < 8; m++) begin
                run_op((m == 7) ? 2'd3 : 2'd0, m[0], m[1], m[2], NR'(l),
                       32'h0001_0000 + 32'(l * 64), 32'h0, l[1], 1'b0);
            end
        end
        // push / pop sweep (R6, R7)
        for (int l = 0; l < 256; l++) begin
            run_op(2'd1, 1'b1, 1'b0, 1'b0, NR'(l), 32'h0, 32'h2000_4000 - 32'(l * 16), l[2], 1'b0);
            run_op(2'd2, 1'b0, 1'b1, 1'b0, NR'(l), 32'h0, 32'h2000_4000 + 32'(l * 16), l[1], 1'b0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule